// File: doc/BRIEF.md
# Interrupt Event Trace Recorder

This block keeps a short history of the interrupt events that a serial bus controller raises during one transaction. Each accepted event is written into a row. A row holds the event code, how many times that event arrived back to back, the transmit-FIFO and receive-FIFO byte counts reported with it, and the value of a free-running tick counter taken when the row was opened. When an event repeats the code of the newest row, it merges into that row instead of taking a new one.

The host pulses a clear input when a new transaction starts. Once the transaction is over, the host reads the rows by index through a combinational read port; the first row is index 1. The event input is a valid/ready stream. Ready is high in every cycle except a clear cycle, so the recorder never stalls the controller. When the buffer is full, a new distinct event is consumed, discarded and flagged.

Top module: `evtrace_recorder`

## Requirements
- R1: After reset, and in the cycle after `clr` is high, `entry_cnt` is 0, `overflow` is 0 and no index reads back as valid.
- R2: An event is accepted when `ev_valid` and `ev_ready` are both high. If the buffer holds fewer than DEPTH rows and the event does not repeat the newest row's code, it opens row `entry_cnt`+1 with repeat count 1, its transmit and receive byte counts, and the current tick. `entry_cnt` then rises by one.
- R3: An accepted event whose code equals the code of the newest row opens no row. It raises that row's repeat count by one and adds its transmit and receive byte counts to the row's sums. The row's code and tick stay unchanged, and so does `entry_cnt`.
- R4: The repeat count is REP_W (16) bits wide and stops at all-ones (65535).
- R5: The transmit and receive sums are SUM_W (16) bits wide, and each stops at all-ones (65535) instead of wrapping.
- R6: The tick counter starts at 0 on reset and advances by one every TICK_DIV (4) clock cycles. `clr` does not reset it. A row stores the tick value that was current in the cycle its opening event was accepted.
- R7: When `entry_cnt` equals DEPTH (32), an accepted event with a new code is dropped and sets `overflow`. `overflow` stays set until clear or reset. An event that repeats the newest row's code still merges into that row.
- R8: When `rd_idx` is between 1 and `entry_cnt`, `rd_valid` is 1 and the row fields appear in the same cycle. When `rd_idx` is 0 or above `entry_cnt`, `rd_valid` is 0 and every row field reads as 0.
- R9: `ev_ready` is low only in a cycle where `clr` is high, so an event presented with `clr` is not recorded. While `ev_valid` is low, the input fields have no effect.
- R10: Repeats are merged only when they are adjacent. The sequence A, B, A produces three rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Start of transaction: empties the buffer and clears the overflow flag |
| ev_valid | input | 1 | Event stream valid |
| ev_ready | output | 1 | Event stream ready; low only during `clr` |
| ev_code | input | EVT_W (16) | Interrupt event code |
| ev_tx | input | BYTE_W (8) | Bytes pushed into the transmit FIFO for this event |
| ev_rx | input | BYTE_W (8) | Bytes drained from the receive FIFO for this event |
| rd_idx | input | clog2(DEPTH+1) (6) | Row to read, 1-based |
| rd_valid | output | 1 | `rd_idx` addresses a filled row |
| rd_code | output | EVT_W (16) | Event code of the addressed row |
| rd_repeat | output | REP_W (16) | Repeat count of the addressed row |
| rd_tx | output | SUM_W (16) | Transmit byte sum of the addressed row |
| rd_rx | output | SUM_W (16) | Receive byte sum of the addressed row |
| rd_tick | output | TICK_W (32) | Tick value when the row was opened |
| entry_cnt | output | clog2(DEPTH+1) (6) | Number of filled rows |
| overflow | output | 1 | Sticky flag: a new event was dropped because the buffer was full |

## Verification
The assertions treat `clr` as a plain level. They assume that an event offered in a clear cycle is meant to be lost, not retried, and that `ev_code` and the byte counts matter only in a cycle where `ev_valid` is high. The stimulus changes every input at the falling clock edge and holds it for one whole cycle. It leaves `ev_valid` high with arbitrary data during `clr` only in the scenario that checks the event is refused. It moves `rd_idx` only while the event stream is idle, so each combinational read sees a settled buffer.

// File: rtl/evtrace_pkg.sv
package evtrace_pkg;

  // Default geometry shared by the recorder and its bench.
  localparam int unsigned DEF_DEPTH    = 32;
  localparam int unsigned DEF_EVT_W    = 16;
  localparam int unsigned DEF_BYTE_W   = 8;
  localparam int unsigned DEF_SUM_W    = 16;
  localparam int unsigned DEF_REP_W    = 16;
  localparam int unsigned DEF_TICK_W   = 32;
  localparam int unsigned DEF_TICK_DIV = 4;

  // What the controller decided to do with this cycle's event.
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_NEW   = 2'd1,
    ACT_MERGE = 2'd2,
    ACT_DROP  = 2'd3
  } evt_act_e;

endpackage

// File: rtl/evtrace_tick.sv
module evtrace_tick #(
  parameter int unsigned TICK_DIV = 4,
  parameter int unsigned TICK_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [TICK_W-1:0] tick
);

  logic step;

  generate
    if (TICK_DIV <= 1) begin : g_nodiv
      assign step = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk) begin
        if (!rst_n)           pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                  pre_q <= pre_q + PW'(1);
      end

      assign step = (pre_q == LAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)    tick <= '0;
    else if (step) tick <= tick + TICK_W'(1);
  end

endmodule

// File: rtl/evtrace_ctrl.sv
module evtrace_ctrl
  import evtrace_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned EVT_W = 16,
  parameter int unsigned CNTW  = 6,
  parameter int unsigned IDXW  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ev_valid,
  input  logic [EVT_W-1:0] ev_code,
  output logic             ev_ready,
  output evt_act_e         act,
  output logic [IDXW-1:0]  wr_row,
  output logic [CNTW-1:0]  entry_cnt,
  output logic             overflow
);

  localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);

  logic [EVT_W-1:0] last_code_q;
  logic             fire;
  logic             same;

  assign ev_ready = ~clr;
  assign fire     = ev_valid & ev_ready;
  assign same     = (entry_cnt != '0) && (ev_code == last_code_q);

  always_comb begin
    act = ACT_IDLE;
    if (fire) begin
      if (same)                    act = ACT_MERGE;
      else if (entry_cnt == FULL)  act = ACT_DROP;
      else                         act = ACT_NEW;
    end
  end

  // A merge targets the newest row; a new event targets the first free row.
  assign wr_row = (act == ACT_MERGE) ? IDXW'(entry_cnt - CNTW'(1)) : IDXW'(entry_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_cnt   <= '0;
      overflow    <= 1'b0;
      last_code_q <= '0;
    end else if (clr) begin
      entry_cnt   <= '0;
      overflow    <= 1'b0;
    end else begin
      unique case (act)
        ACT_NEW: begin
          entry_cnt   <= entry_cnt + CNTW'(1);
          last_code_q <= ev_code;
        end
        ACT_DROP: overflow <= 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/evtrace_store.sv
module evtrace_store
  import evtrace_pkg::*;
#(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned EVT_W  = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SUM_W  = 16,
  parameter int unsigned REP_W  = 16,
  parameter int unsigned TICK_W = 32,
  parameter int unsigned IDXW   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  evt_act_e          act,
  input  logic [IDXW-1:0]   wr_row,
  input  logic [EVT_W-1:0]  ev_code,
  input  logic [BYTE_W-1:0] ev_tx,
  input  logic [BYTE_W-1:0] ev_rx,
  input  logic [TICK_W-1:0] tick,
  input  logic [IDXW-1:0]   rd_row,
  output logic [EVT_W-1:0]  rd_code,
  output logic [REP_W-1:0]  rd_repeat,
  output logic [SUM_W-1:0]  rd_tx,
  output logic [SUM_W-1:0]  rd_rx,
  output logic [TICK_W-1:0] rd_tick
);

  logic [EVT_W-1:0]  code_q [DEPTH];
  logic [REP_W-1:0]  rep_q  [DEPTH];
  logic [SUM_W-1:0]  tx_q   [DEPTH];
  logic [SUM_W-1:0]  rx_q   [DEPTH];
  logic [TICK_W-1:0] tick_q [DEPTH];

  // One shared merge datapath working on the addressed row.
  logic [REP_W:0]   rep_sum;
  logic [SUM_W:0]   tx_sum;
  logic [SUM_W:0]   rx_sum;
  logic [REP_W-1:0] rep_nxt;
  logic [SUM_W-1:0] tx_nxt;
  logic [SUM_W-1:0] rx_nxt;

  assign rep_sum = {1'b0, rep_q[wr_row]} + (REP_W+1)'(1);
  assign tx_sum  = {1'b0, tx_q[wr_row]}  + (SUM_W+1)'(ev_tx);
  assign rx_sum  = {1'b0, rx_q[wr_row]}  + (SUM_W+1)'(ev_rx);
  assign rep_nxt = rep_sum[REP_W] ? '1 : rep_sum[REP_W-1:0];
  assign tx_nxt  = tx_sum[SUM_W]  ? '1 : tx_sum[SUM_W-1:0];
  assign rx_nxt  = rx_sum[SUM_W]  ? '1 : rx_sum[SUM_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < DEPTH; r++) begin
        code_q[r] <= '0;
        rep_q[r]  <= '0;
        tx_q[r]   <= '0;
        rx_q[r]   <= '0;
        tick_q[r] <= '0;
      end
    end else begin
      unique case (act)
        ACT_NEW: begin
          code_q[wr_row] <= ev_code;
          rep_q[wr_row]  <= REP_W'(1);
          tx_q[wr_row]   <= SUM_W'(ev_tx);
          rx_q[wr_row]   <= SUM_W'(ev_rx);
          tick_q[wr_row] <= tick;
        end
        ACT_MERGE: begin
          rep_q[wr_row] <= rep_nxt;
          tx_q[wr_row]  <= tx_nxt;
          rx_q[wr_row]  <= rx_nxt;
        end
        default: ;
      endcase
    end
  end

  assign rd_code   = code_q[rd_row];
  assign rd_repeat = rep_q[rd_row];
  assign rd_tx     = tx_q[rd_row];
  assign rd_rx     = rx_q[rd_row];
  assign rd_tick   = tick_q[rd_row];

endmodule

// File: rtl/evtrace_recorder.sv
module evtrace_recorder
  import evtrace_pkg::*;
#(
  parameter int unsigned DEPTH    = DEF_DEPTH,
  parameter int unsigned EVT_W    = DEF_EVT_W,
  parameter int unsigned BYTE_W   = DEF_BYTE_W,
  parameter int unsigned SUM_W    = DEF_SUM_W,
  parameter int unsigned REP_W    = DEF_REP_W,
  parameter int unsigned TICK_W   = DEF_TICK_W,
  parameter int unsigned TICK_DIV = DEF_TICK_DIV,
  localparam int unsigned CNTW    = $clog2(DEPTH + 1),
  localparam int unsigned IDXW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [EVT_W-1:0]  ev_code,
  input  logic [BYTE_W-1:0] ev_tx,
  input  logic [BYTE_W-1:0] ev_rx,
  input  logic [CNTW-1:0]   rd_idx,
  output logic              rd_valid,
  output logic [EVT_W-1:0]  rd_code,
  output logic [REP_W-1:0]  rd_repeat,
  output logic [SUM_W-1:0]  rd_tx,
  output logic [SUM_W-1:0]  rd_rx,
  output logic [TICK_W-1:0] rd_tick,
  output logic [CNTW-1:0]   entry_cnt,
  output logic              overflow
);

  evt_act_e          act;
  logic [IDXW-1:0]   wr_row;
  logic [IDXW-1:0]   rd_row;
  logic [TICK_W-1:0] tick;
  logic [EVT_W-1:0]  row_code;
  logic [REP_W-1:0]  row_rep;
  logic [SUM_W-1:0]  row_tx;
  logic [SUM_W-1:0]  row_rx;
  logic [TICK_W-1:0] row_tick;

  evtrace_tick #(.TICK_DIV(TICK_DIV), .TICK_W(TICK_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  evtrace_ctrl #(.DEPTH(DEPTH), .EVT_W(EVT_W), .CNTW(CNTW), .IDXW(IDXW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .ev_valid  (ev_valid),
    .ev_code   (ev_code),
    .ev_ready  (ev_ready),
    .act       (act),
    .wr_row    (wr_row),
    .entry_cnt (entry_cnt),
    .overflow  (overflow)
  );

  evtrace_store #(
    .DEPTH(DEPTH), .EVT_W(EVT_W), .BYTE_W(BYTE_W), .SUM_W(SUM_W),
    .REP_W(REP_W), .TICK_W(TICK_W), .IDXW(IDXW)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (act),
    .wr_row    (wr_row),
    .ev_code   (ev_code),
    .ev_tx     (ev_tx),
    .ev_rx     (ev_rx),
    .tick      (tick),
    .rd_row    (rd_row),
    .rd_code   (row_code),
    .rd_repeat (row_rep),
    .rd_tx     (row_tx),
    .rd_rx     (row_rx),
    .rd_tick   (row_tick)
  );

  // 1-based host index; rows past the fill level read as zero.
  assign rd_valid  = (rd_idx != '0) && (rd_idx <= entry_cnt);
  assign rd_row    = IDXW'(rd_idx - CNTW'(1));
  assign rd_code   = rd_valid ? row_code : '0;
  assign rd_repeat = rd_valid ? row_rep  : '0;
  assign rd_tx     = rd_valid ? row_tx   : '0;
  assign rd_rx     = rd_valid ? row_rx   : '0;
  assign rd_tick   = rd_valid ? row_tick : '0;

endmodule

// File: rtl/evtrace_recorder_chk.sv
module evtrace_recorder_chk #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned REP_W = 16,
  parameter int unsigned CNTW  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             ev_valid,
  input logic [CNTW-1:0]  entry_cnt,
  input logic             overflow,
  input logic             rd_valid,
  input logic [REP_W-1:0] rd_repeat
);

  localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);

  // R1
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (entry_cnt == '0 && !overflow));

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_cnt <= FULL);

  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr) |=> overflow);

  // R7
  overflow_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> ($past(entry_cnt) == FULL));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (entry_cnt == $past(entry_cnt) || entry_cnt == $past(entry_cnt) + CNTW'(1)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_valid && !clr) |=> (entry_cnt == $past(entry_cnt)));

  // R8
  valid_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_repeat != '0));

endmodule

bind evtrace_recorder evtrace_recorder_chk #(.DEPTH(DEPTH), .REP_W(REP_W), .CNTW(CNTW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .ev_valid  (ev_valid),
  .entry_cnt (entry_cnt),
  .overflow  (overflow),
  .rd_valid  (rd_valid),
  .rd_repeat (rd_repeat)
);

// File: tb/evtrace_recorder_test.sv
module evtrace_recorder_test;

  localparam int DEPTH = 32;
  localparam int DIV   = 4;
  localparam int SAT   = 65535;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [15:0] ev_code = '0;
  logic [7:0]  ev_tx = '0;
  logic [7:0]  ev_rx = '0;
  logic [5:0]  rd_idx = '0;
  logic        rd_valid;
  logic [15:0] rd_code;
  logic [15:0] rd_repeat;
  logic [15:0] rd_tx;
  logic [15:0] rd_rx;
  logic [31:0] rd_tick;
  logic [5:0]  entry_cnt;
  logic        overflow;

  evtrace_recorder uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_code(ev_code), .ev_tx(ev_tx), .ev_rx(ev_rx), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_code(rd_code), .rd_repeat(rd_repeat), .rd_tx(rd_tx),
    .rd_rx(rd_rx), .rd_tick(rd_tick), .entry_cnt(entry_cnt), .overflow(overflow)
  );

  always #4 clk = ~clk;

  // Clock edges seen since reset release: the basis of the expected tick.
  int ec = 0;
  always @(posedge clk) begin
    if (!rst_n) ec <= 0;
    else        ec <= ec + 1;
  end

  int vectors = 0;
  int fails   = 0;

  // Reference rows, 1-based.
  int m_code [1:DEPTH];
  int m_rep  [1:DEPTH];
  int m_tx   [1:DEPTH];
  int m_rx   [1:DEPTH];
  int m_tick [1:DEPTH];
  int m_cnt = 0;
  bit m_ovf = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > SAT) ? SAT : v;
  endfunction

  function automatic void m_apply(input int c, input int tx, input int rx, input int t);
    if (m_cnt > 0 && c == m_code[m_cnt]) begin
      m_rep[m_cnt] = sat(m_rep[m_cnt] + 1);
      m_tx[m_cnt]  = sat(m_tx[m_cnt] + tx);
      m_rx[m_cnt]  = sat(m_rx[m_cnt] + rx);
    end else if (m_cnt == DEPTH) begin
      m_ovf = 1;
    end else begin
      m_cnt++;
      m_code[m_cnt] = c; m_rep[m_cnt] = 1;
      m_tx[m_cnt] = tx; m_rx[m_cnt] = rx; m_tick[m_cnt] = t;
    end
  endfunction

  // Called at a falling edge; returns at the next falling edge.
  task automatic send(input int c, input int tx, input int rx);
    ev_valid = 1'b1;
    ev_code  = 16'(c);
    ev_tx    = 8'(tx);
    ev_rx    = 8'(rx);
    m_apply(c, tx, rx, ec / DIV);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    m_cnt = 0;
    m_ovf = 0;
  endtask

  task automatic check_row(input int i, input string req);
    rd_idx = 6'(i);
    #1;
    chk(rd_valid == 1'b1, {req, " rd_valid"}, rd_valid, 1);
    chk(rd_code == 16'(m_code[i]), {req, " code"}, rd_code, m_code[i]);
    chk(rd_repeat == 16'(m_rep[i]), {req, " repeat"}, rd_repeat, m_rep[i]);
    chk(rd_tx == 16'(m_tx[i]), {req, " tx"}, rd_tx, m_tx[i]);
    chk(rd_rx == 16'(m_rx[i]), {req, " rx"}, rd_rx, m_rx[i]);
    chk(rd_tick == 32'(m_tick[i]), {req, " tick"}, rd_tick, m_tick[i]);
    @(negedge clk);
  endtask

  task automatic check_state(input string req);
    chk(entry_cnt == 6'(m_cnt), {req, " entry_cnt"}, entry_cnt, m_cnt);
    chk(overflow == m_ovf, {req, " overflow"}, overflow, m_ovf);
  endtask

  task automatic t_reset();
    rd_idx = 6'd1;
    #1;
    chk(entry_cnt == 0, "R1 reset entry_cnt", entry_cnt, 0);
    chk(overflow == 0, "R1 reset overflow", overflow, 0);
    chk(rd_valid == 0, "R1 reset rd_valid", rd_valid, 0);
    chk(ev_ready == 1, "R9 ready after reset", ev_ready, 1);
    @(negedge clk);
  endtask

  task automatic t_distinct();
    send(16'h0002, 3, 0);
    repeat (5) @(negedge clk);
    send(16'h0200, 0, 1);
    send(16'h0080, 0, 8);
    check_state("R2 distinct");
    for (int i = 1; i <= 3; i++) check_row(i, "R2/R6 distinct row");
  endtask

  task automatic t_merge();
    do_clear();
    send(16'h0011, 2, 1);
    repeat (3) @(negedge clk);
    send(16'h0011, 4, 5);
    send(16'h0011, 1, 0);
    check_state("R3 merge");
    check_row(1, "R3 merged row");
    send(16'h0022, 0, 0);
    send(16'h0011, 7, 7);
    check_state("R10 non-adjacent");
    for (int i = 1; i <= 3; i++) check_row(i, "R10 row");
  endtask

  task automatic t_clear_blocks();
    clr = 1'b1;
    ev_valid = 1'b1;
    ev_code = 16'h0BAD;
    #1;
    chk(ev_ready == 0, "R9 ready low in clear", ev_ready, 0);
    @(negedge clk);
    clr = 1'b0;
    ev_valid = 1'b0;
    m_cnt = 0;
    m_ovf = 0;
    check_state("R1/R9 clear drops event");
    rd_idx = 6'd1;
    #1;
    chk(rd_valid == 0, "R1 no valid row after clear", rd_valid, 0);
    @(negedge clk);
    // R9: valid low with live data does nothing
    ev_code = 16'h0077; ev_tx = 8'd9;
    repeat (4) @(negedge clk);
    check_state("R9 idle input");
    repeat (7) @(negedge clk);
    send(16'h0044, 1, 2);
    check_row(1, "R6 tick survives clear");
  endtask

  task automatic t_read_range();
    rd_idx = 6'd0;
    #1;
    chk(rd_valid == 0, "R8 idx0 valid", rd_valid, 0);
    chk(rd_code == 0 && rd_repeat == 0 && rd_tick == 0, "R8 idx0 zero fields", rd_code, 0);
    @(negedge clk);
    rd_idx = 6'(m_cnt + 1);
    #1;
    chk(rd_valid == 0, "R8 past-end valid", rd_valid, 0);
    chk(rd_tx == 0 && rd_rx == 0 && rd_repeat == 0, "R8 past-end zero fields", rd_repeat, 0);
    @(negedge clk);
  endtask

  task automatic t_overflow();
    do_clear();
    for (int i = 0; i < DEPTH; i++) send(16'h0100 + i, i, 1);
    check_state("R7 filled");
    chk(overflow == 0, "R7 no overflow at exactly full", overflow, 0);
    send(16'h0F00, 1, 1);
    check_state("R7 drop sets overflow");
    send(16'h0100 + DEPTH - 1, 5, 6);
    check_state("R7 merge while full");
    check_row(DEPTH, "R7 last row merged");
    check_row(1, "R7 first row intact");
    send(16'h0F01, 0, 0);
    repeat (2) @(negedge clk);
    check_state("R7 overflow sticky");
    do_clear();
    check_state("R1 clear resets overflow");
  endtask

  task automatic t_sum_sat();
    send(16'h0055, 255, 200);
    for (int i = 0; i < 299; i++) send(16'h0055, 255, 200);
    check_state("R5 sums");
    check_row(1, "R5 tx saturates rx sums");
  endtask

  task automatic t_rep_sat();
    do_clear();
    for (int i = 0; i < 65540; i++) send(16'h0066, 0, 0);
    check_state("R4 repeat");
    check_row(1, "R4 repeat saturates");
    chk(rd_repeat == 16'hFFFF, "R4 repeat all-ones", rd_repeat, SAT);
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_distinct();
    t_merge();
    t_clear_blocks();
    t_read_range();
    t_overflow();
    t_sum_sat();
    t_rep_sat();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule